// File: doc/BRIEF.md
# Input Channel Scan Sequencer

This block decides which analog input the converter samples next and labels each finished conversion with the number of the channel it came from. Software sets it up over a three-wire serial port: clock, chip select and data-in, plus a data-out line for reads. The port reaches a bank of eight byte-wide registers. One register holds a mode byte, one takes conversion commands, and one holds a per-channel enable mask. The other five are plain storage.

Channel codes are three bits wide. Codes 6 and 7 are the two calibration inputs: 6 is the offset reference and 7 is the gain reference. The normal inputs are either three fully differential pairs (codes 0 to 2) or five pseudo-differential inputs (codes 0 to 4), and a mode bit chooses between the two.

With the scan bit clear, the sequencer converts only when a command names a legal channel. With the scan bit set, it cycles without stopping through every enabled legal channel in ascending order. For each conversion it drives the mux-select output, pulses a start strobe, waits for the converter's done pulse, and then presents the result word together with its channel tag.

Top module: `scan_sequencer`

## Requirements
- R1: After reset, mux_sel, start_conv, res_valid and spi_sdo are all 0, and every register reads back 0.
- R2: A serial frame is 12 bits long and is sampled on rising edges of spi_sclk while spi_cs_n is low. The bits are, in order: a read flag (1 = read, 0 = write), a 3-bit register address sent MSB first, then 8 data bits sent MSB first. A write takes effect only when the 12th rising edge arrives. Raising spi_cs_n earlier discards the frame.
- R3: During a read frame, the addressed register's 8 bits appear on spi_sdo MSB first. Each bit is valid at rising edges 5 through 12 and changes only after a falling edge. All eight addresses hold whatever was written to them.
- R4: Register map. Address 0 holds the mode byte: bit 0 is the scan flag and bit 1 selects pseudo-differential mode. A write to address 1 is a command naming a channel in bits 2:0. At address 2, bit i enables channel i for scanning.
- R5: Legal channel codes are 0 to 2, 6 and 7 in differential mode, and 0 to 4, 6 and 7 in pseudo-differential mode. A command for any other code starts nothing.
- R6: While scan is clear and the sequencer is idle, a command for a legal channel produces exactly one single-cycle start_conv pulse, with mux_sel equal to that channel. A command that arrives while a conversion is in progress is ignored.
- R7: mux_sel holds its value from the start_conv pulse until the converter's conv_done is accepted.
- R8: In the cycle after conv_done is accepted, res_valid is high for one cycle, res_data carries conv_data, and res_tag carries the converted channel. A conv_done pulse while idle produces no result.
- R9: With scan set, conversions repeat. They begin at the lowest enabled legal channel and step upward through enabled legal channels, wrapping from the highest back to the lowest. Each new start_conv coincides with the previous res_valid. With no enabled legal channel, nothing starts.
- R10: When scan is cleared mid-conversion, the conversion in flight completes and reports its result, and no further conversion starts.
- R11: Commands written while scan is set start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock, idles low |
| spi_cs_n | input | 1 | Serial chip select, active low |
| spi_sdi | input | 1 | Serial data into the block |
| spi_sdo | output | 1 | Serial read data out of the block |
| mux_sel | output | 3 | Channel code driven to the analog multiplexer |
| start_conv | output | 1 | One-cycle conversion start strobe |
| conv_done | input | 1 | Converter finished pulse |
| conv_data | input | DATA_W | Converter result, valid with conv_done |
| res_valid | output | 1 | Tagged result valid strobe |
| res_data | output | DATA_W | Result word |
| res_tag | output | 3 | Channel identifier of the result |

## Verification
The bench builds the block with DATA_W set to 12 rather than the default 16. This checks that the result path follows the parameter and does not depend on a fixed width. The synchronizer depth stays at 2. With that depth, the serial edges reach the register file a few cycles after the pins change, so both the read data timing and the timing of a write commit are tested. The bench varies the converter latency from a few cycles up to several hundred. This lets a command frame arrive in full while a conversion is pending, and lets the scan bit be cleared at varying points in a scan.

// File: rtl/scanseq_pkg.sv
package scanseq_pkg;
  localparam int CH_W      = 3;
  localparam int NCH       = 1 << CH_W;
  localparam int REG_AW    = 3;
  localparam int REG_DW    = 8;
  localparam int NREG      = 1 << REG_AW;
  localparam int FRAME_LEN = 1 + REG_AW + REG_DW;
  localparam int N_DIFF    = 3;
  localparam int N_PSEUDO  = 5;
  localparam int CAL_OFS_CH  = 6;
  localparam int CAL_GAIN_CH = 7;

  localparam logic [REG_AW-1:0] ADDR_MODE = REG_AW'(0);
  localparam logic [REG_AW-1:0] ADDR_CMD  = REG_AW'(1);
  localparam logic [REG_AW-1:0] ADDR_MASK = REG_AW'(2);

  typedef enum logic {SEQ_IDLE = 1'b0, SEQ_CONV = 1'b1} seq_state_t;

  // Set of channel codes that exist in the chosen input arrangement
  function automatic logic [NCH-1:0] legal_channels(input logic pseudo);
    logic [NCH-1:0] v;
    int n;
    n = pseudo ? N_PSEUDO : N_DIFF;
    for (int i = 0; i < NCH; i++)
      v[i] = (i < n) || (i == CAL_OFS_CH) || (i == CAL_GAIN_CH);
    return v;
  endfunction

  // First set bit of m strictly after cur, wrapping; cur itself last
  function automatic logic [CH_W-1:0] next_channel(input logic [CH_W-1:0] cur,
                                                   input logic [NCH-1:0] m);
    logic [CH_W-1:0] r;
    logic found;
    r = cur;
    found = 1'b0;
    for (int i = 1; i <= NCH; i++) begin
      logic [CH_W-1:0] c;
      c = cur + CH_W'(i);
      if (!found && m[c]) begin
        r = c;
        found = 1'b1;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/scanseq_serial_port.sv
module scanseq_serial_port #(
  parameter int AW    = 3,
  parameter int DW    = 8,
  parameter int SYNC  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk,
  input  logic          cs_n,
  input  logic          sdi,
  output logic          sdo,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  localparam int FRAME = 1 + AW + DW;
  localparam int CNT_W = $clog2(FRAME + 1);
  localparam logic [CNT_W-1:0] CNT_ADDR_LAST = CNT_W'(AW);
  localparam logic [CNT_W-1:0] CNT_FIRST_SH  = CNT_W'(AW + 1);
  localparam logic [CNT_W-1:0] CNT_LAST      = CNT_W'(FRAME - 1);
  localparam logic [CNT_W-1:0] CNT_FULL      = CNT_W'(FRAME);

  logic [SYNC-1:0] sclk_q, cs_q, sdi_q;
  logic            sclk_prev;
  logic            sclk_s, cs_s, sdi_s;
  logic            rise, fall;
  logic [CNT_W-1:0] cnt;
  logic [FRAME-2:0] rx;
  logic [DW-1:0]    tx;
  logic             reading;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q    <= '0;
      cs_q      <= '1;
      sdi_q     <= '0;
      sclk_prev <= 1'b0;
    end else begin
      sclk_q    <= {sclk_q[SYNC-2:0], sclk};
      cs_q      <= {cs_q[SYNC-2:0], cs_n};
      sdi_q     <= {sdi_q[SYNC-2:0], sdi};
      sclk_prev <= sclk_s;
    end
  end

  assign sclk_s = sclk_q[SYNC-1];
  assign cs_s   = cs_q[SYNC-1];
  assign sdi_s  = sdi_q[SYNC-1];
  assign rise   = sclk_s & ~sclk_prev & ~cs_s;
  assign fall   = ~sclk_s & sclk_prev & ~cs_s;

  // address is complete on the rise that brings in its last bit
  assign rd_addr = {rx[AW-2:0], sdi_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      rx      <= '0;
      tx      <= '0;
      reading <= 1'b0;
    end else if (cs_s) begin
      cnt     <= '0;
      reading <= 1'b0;
      tx      <= '0;
    end else begin
      if (rise && cnt < CNT_FULL) begin
        rx  <= {rx[FRAME-3:0], sdi_s};
        cnt <= cnt + 1'b1;
        if (cnt == CNT_ADDR_LAST) begin
          reading <= rx[AW-1];
          tx      <= rd_data;
        end
      end
      if (fall && cnt > CNT_FIRST_SH && cnt < CNT_FULL)
        tx <= {tx[DW-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= rise && (cnt == CNT_LAST) && !rx[FRAME-2];
      if (rise && cnt == CNT_LAST) begin
        wr_addr <= rx[FRAME-3 -: AW];
        wr_data <= {rx[DW-2:0], sdi_s};
      end
    end
  end

  assign sdo = reading & ~cs_s & tx[DW-1];
endmodule

// File: rtl/scanseq_regs.sv
module scanseq_regs
  import scanseq_pkg::*;
#(
  parameter int AW = REG_AW,
  parameter int DW = REG_DW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic [AW-1:0]  rd_addr,
  output logic [DW-1:0]  rd_data,
  output logic           scan_en,
  output logic           pseudo,
  output logic [NCH-1:0] chan_mask,
  output logic           cmd_fire,
  output logic [CH_W-1:0] cmd_chan
);
  localparam int NR = 1 << AW;

  logic [DW-1:0] regs [NR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NR; i++) regs[i] <= '0;
    end else if (wr_en) begin
      regs[wr_addr] <= wr_data;
    end
  end

  assign rd_data   = regs[rd_addr];
  assign scan_en   = regs[ADDR_MODE][0];
  assign pseudo    = regs[ADDR_MODE][1];
  assign chan_mask = regs[ADDR_MASK][NCH-1:0];
  assign cmd_fire  = wr_en && (wr_addr == ADDR_CMD);
  assign cmd_chan  = wr_data[CH_W-1:0];
endmodule

// File: rtl/scanseq_ctrl.sv
module scanseq_ctrl
  import scanseq_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scan_en,
  input  logic            pseudo,
  input  logic [NCH-1:0]  chan_mask,
  input  logic            cmd_fire,
  input  logic [CH_W-1:0] cmd_chan,
  input  logic            conv_done,
  input  logic [DW-1:0]   conv_data,
  output logic [CH_W-1:0] mux_sel,
  output logic            start_conv,
  output logic            res_valid,
  output logic [DW-1:0]   res_data,
  output logic [CH_W-1:0] res_tag,
  output logic            busy,
  output logic            cmd_accept,
  output logic            scan_step
);
  seq_state_t      state;
  logic [CH_W-1:0] chan;
  logic [NCH-1:0]  legal, eff_mask;
  logic            any_enabled, scan_begin;

  assign legal       = legal_channels(pseudo);
  assign eff_mask    = chan_mask & legal;
  assign any_enabled = |eff_mask;
  assign busy        = (state == SEQ_CONV);
  assign cmd_accept  = !busy && !scan_en && cmd_fire && legal[cmd_chan];
  assign scan_begin  = !busy && scan_en && any_enabled;
  assign scan_step   = busy && conv_done && scan_en && any_enabled;
  assign mux_sel     = chan;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= SEQ_IDLE;
      chan       <= '0;
      start_conv <= 1'b0;
      res_valid  <= 1'b0;
      res_data   <= '0;
      res_tag    <= '0;
    end else begin
      start_conv <= 1'b0;
      res_valid  <= 1'b0;
      case (state)
        SEQ_IDLE: begin
          if (scan_begin) begin
            chan       <= next_channel(CH_W'(NCH - 1), eff_mask);
            start_conv <= 1'b1;
            state      <= SEQ_CONV;
          end else if (cmd_accept) begin
            chan       <= cmd_chan;
            start_conv <= 1'b1;
            state      <= SEQ_CONV;
          end
        end
        SEQ_CONV: begin
          if (conv_done) begin
            res_valid <= 1'b1;
            res_data  <= conv_data;
            res_tag   <= chan;
            if (scan_step) begin
              chan       <= next_channel(chan, eff_mask);
              start_conv <= 1'b1;
            end else begin
              state <= SEQ_IDLE;
            end
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
  import scanseq_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_sdi,
  output logic              spi_sdo,
  output logic [CH_W-1:0]   mux_sel,
  output logic              start_conv,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic [CH_W-1:0]   res_tag
);
  logic [REG_AW-1:0] rd_addr, wr_addr;
  logic [REG_DW-1:0] rd_data, wr_data;
  logic              wr_en;
  logic              scan_en, pseudo, cmd_fire;
  logic [NCH-1:0]    chan_mask;
  logic [CH_W-1:0]   cmd_chan;
  logic              busy, cmd_accept, scan_step;

  scanseq_serial_port #(.AW(REG_AW), .DW(REG_DW), .SYNC(SYNC_STAGES)) u_port (
    .clk(clk), .rst_n(rst_n),
    .sclk(spi_sclk), .cs_n(spi_cs_n), .sdi(spi_sdi), .sdo(spi_sdo),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  scanseq_regs #(.AW(REG_AW), .DW(REG_DW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .scan_en(scan_en), .pseudo(pseudo), .chan_mask(chan_mask),
    .cmd_fire(cmd_fire), .cmd_chan(cmd_chan)
  );

  scanseq_ctrl #(.DW(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .scan_en(scan_en), .pseudo(pseudo), .chan_mask(chan_mask),
    .cmd_fire(cmd_fire), .cmd_chan(cmd_chan),
    .conv_done(conv_done), .conv_data(conv_data),
    .mux_sel(mux_sel), .start_conv(start_conv),
    .res_valid(res_valid), .res_data(res_data), .res_tag(res_tag),
    .busy(busy), .cmd_accept(cmd_accept), .scan_step(scan_step)
  );
endmodule

// File: rtl/scanseq_chk.sv
module scanseq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       start_conv,
  input logic       conv_done,
  input logic [2:0] mux_sel,
  input logic       res_valid,
  input logic [2:0] res_tag,
  input logic       scan_en,
  input logic       cmd_fire,
  input logic       cmd_accept,
  input logic       scan_step
);
  // R6
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_conv |=> !start_conv);

  // R7
  mux_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !conv_done) |=> $stable(mux_sel));

  // R8
  result_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ($past(conv_done) && $past(busy)));

  // R8
  result_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_tag == $past(mux_sel)));

  // R8
  idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && conv_done) |=> !res_valid);

  // R9
  scan_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_step |=> (start_conv && res_valid));

  // R11
  scan_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && cmd_fire) |-> !cmd_accept);

  // R6
  busy_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_fire) |=> !start_conv || $past(conv_done));
endmodule

bind scan_sequencer scanseq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .start_conv(start_conv),
  .conv_done(conv_done), .mux_sel(mux_sel), .res_valid(res_valid),
  .res_tag(res_tag), .scan_en(scan_en), .cmd_fire(cmd_fire),
  .cmd_accept(cmd_accept), .scan_step(scan_step)
);

// File: tb/scan_sequencer_tb.sv
module scan_sequencer_tb;
  localparam int DW = 12;
  localparam int LOGMAX = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0;
  logic sdo;
  logic [2:0] mux_sel, res_tag;
  logic start_conv, conv_done, res_valid;
  logic [DW-1:0] conv_data, res_data;

  always #10 clk = ~clk;

  scan_sequencer #(.DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_sdi(sdi),
    .spi_sdo(sdo), .mux_sel(mux_sel), .start_conv(start_conv),
    .conv_done(conv_done), .conv_data(conv_data), .res_valid(res_valid),
    .res_data(res_data), .res_tag(res_tag)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // converter model and result monitor
  int lat = 6;
  int start_cnt = 0, logn = 0, cd = 0;
  bit pend = 0, resp_done = 0, stray_done = 0;
  logic [2:0] cap_ch = 0, ret_ch = 0;
  logic [DW-1:0] ret_data = 0;
  logic [2:0] logt [LOGMAX];

  assign conv_done = resp_done | stray_done;
  assign conv_data = ret_data;

  always @(negedge clk) begin
    if (!rst_n) begin
      pend = 0;
      resp_done = 0;
    end else begin
      if (res_valid) begin
        chk(res_tag == ret_ch, "R8 tag", res_tag, ret_ch);
        chk(res_data == ret_data, "R8 data", res_data, ret_data);
        if (logn < LOGMAX) logt[logn] = res_tag;
        logn++;
      end
      resp_done = 0;
      if (pend) begin
        if (cd == 0) begin
          chk(mux_sel == cap_ch, "R7 mux held", mux_sel, cap_ch);
          ret_ch = cap_ch;
          ret_data = DW'($urandom);
          resp_done = 1;
          pend = 0;
        end else cd--;
      end
      if (start_conv) begin
        start_cnt++;
        pend = 1;
        cd = lat;
        cap_ch = mux_sel;
      end
    end
  end

  // independent restatement of the channel rules
  function automatic bit exp_legal(input int ch, input bit pseudo);
    case (ch)
      0, 1, 2, 6, 7: return 1;
      3, 4: return pseudo;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_next(input int cur, input logic [7:0] m);
    for (int c = cur + 1; c < 8; c++) if (m[c]) return c;
    for (int c = 0; c <= cur; c++) if (m[c]) return c;
    return -1;
  endfunction

  task automatic spi_xfer(input bit rw, input logic [2:0] a, input logic [7:0] d,
                          input int nbits, output logic [7:0] q);
    logic [11:0] fr;
    fr = {rw, a, d};
    q = 0;
    @(negedge clk);
    cs_n = 0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdi = fr[11-i];
      repeat (4) @(negedge clk);
      if (i >= 4) q = {q[6:0], sdo};
      sclk = 1;
      repeat (4) @(negedge clk);
      sclk = 0;
    end
    repeat (4) @(negedge clk);
    cs_n = 1;
    repeat (8) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    logic [7:0] q;
    spi_xfer(1'b0, a, d, 12, q);
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] q);
    spi_xfer(1'b1, a, 8'h00, 12, q);
  endtask

  task automatic do_cmd(input int ch, input bit pseudo, input string req);
    int s0, b0;
    bit expect_go;
    expect_go = exp_legal(ch, pseudo);
    s0 = start_cnt;
    b0 = logn;
    wr(3'd1, 8'(ch));
    repeat (60) @(negedge clk);
    chk(start_cnt == s0 + (expect_go ? 1 : 0), req, start_cnt - s0, expect_go ? 1 : 0);
    chk(logn == b0 + (expect_go ? 1 : 0), req, logn - b0, expect_go ? 1 : 0);
    if (expect_go && logn > b0) chk(logt[b0] == 3'(ch), req, logt[b0], ch);
  endtask

  task automatic scan_run(input bit pseudo, input logic [7:0] mask, input int nres);
    logic [7:0] m;
    int b0, e, s1, w;
    m = mask;
    for (int c = 0; c < 8; c++) if (!exp_legal(c, pseudo)) m[c] = 0;
    wr(3'd0, {6'd0, pseudo, 1'b0});
    wr(3'd2, mask);
    b0 = logn;
    wr(3'd0, {6'd0, pseudo, 1'b1});
    if (m == 0) begin
      repeat (300) @(negedge clk);
      chk(logn == b0, "R9 empty mask", logn - b0, 0);
    end else begin
      w = 0;
      while (logn < b0 + nres && w < 20000) begin
        @(negedge clk);
        w++;
      end
      e = exp_next(7, m);
      for (int k = 0; k < nres; k++) begin
        chk(int'(logt[b0+k]) == e, "R9 order", logt[b0+k], e);
        e = exp_next(e, m);
      end
    end
    wr(3'd0, {6'd0, pseudo, 1'b0});
    repeat (lat + 20) @(negedge clk);
    chk(start_cnt == logn, "R10 in-flight done", logn, start_cnt);
    s1 = start_cnt;
    repeat (200) @(negedge clk);
    chk(start_cnt == s1, "R10 no restart", start_cnt, s1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      chk(0, "watchdog", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] q;
    logic [7:0] vals [8];
    int s0, b0, tagc;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(mux_sel == 0, "R1 mux_sel", mux_sel, 0);
    chk(start_conv == 0, "R1 start_conv", start_conv, 0);
    chk(res_valid == 0, "R1 res_valid", res_valid, 0);
    chk(sdo == 0, "R1 sdo", sdo, 0);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), q);
      chk(q == 0, "R1 reg reset", q, 0);
    end

    // R2 R3: storage and readback; keep scan off at address 0 and commands harmless
    for (int a = 3; a < 8; a++) begin
      vals[a] = 8'($urandom);
      wr(3'(a), vals[a]);
    end
    vals[2] = 8'($urandom);
    wr(3'd2, vals[2]);
    wr(3'd0, 8'hfc);
    vals[0] = 8'hfc;
    for (int a = 0; a < 8; a++) begin
      if (a == 1) continue;
      rd(3'(a), q);
      chk(q == vals[a], "R3 readback", q, vals[a]);
    end
    wr(3'd0, 8'h00);
    // R2: aborted write frame leaves the register unchanged
    spi_xfer(1'b0, 3'd5, ~vals[5], 9, q);
    rd(3'd5, q);
    chk(q == vals[5], "R2 aborted frame", q, vals[5]);
    rd(3'd0, q);
    chk(q == 0, "R2 mode rewrite", q, 0);

    // R6 R4: single commands, differential mode
    do_cmd(1, 0, "R6 cmd ch1");
    do_cmd(6, 0, "R6 cmd offset cal");
    do_cmd(7, 0, "R6 cmd gain cal");
    // R5: codes outside differential set
    do_cmd(3, 0, "R5 diff ch3 ignored");
    do_cmd(5, 0, "R5 diff ch5 ignored");
    wr(3'd0, 8'h02);
    do_cmd(4, 1, "R5 pseudo ch4");
    do_cmd(5, 1, "R5 pseudo ch5 ignored");

    // R8: stray done while idle
    b0 = logn;
    @(negedge clk);
    stray_done = 1;
    @(negedge clk);
    stray_done = 0;
    repeat (10) @(negedge clk);
    chk(logn == b0, "R8 idle done ignored", logn - b0, 0);

    // random commands with random mode
    for (int it = 0; it < 16; it++) begin
      bit p;
      int ch;
      p = 1'($urandom);
      ch = int'($urandom % 8);
      lat = 2 + int'($urandom % 20);
      wr(3'd0, {6'd0, p, 1'b0});
      do_cmd(ch, p, "R6 random cmd");
    end

    // R6: command during a long conversion is ignored
    wr(3'd0, 8'h00);
    lat = 400;
    s0 = start_cnt;
    b0 = logn;
    wr(3'd1, 8'd0);
    wr(3'd1, 8'd2);
    repeat (500) @(negedge clk);
    chk(start_cnt == s0 + 1, "R6 busy cmd ignored", start_cnt - s0, 1);
    chk(logn == b0 + 1 && logt[b0] == 0, "R6 busy cmd tag", logt[b0], 0);
    lat = 6;

    // R9 R10: scan with wrap, several masks and modes
    scan_run(0, 8'hff, 12);
    scan_run(1, 8'hff, 16);
    scan_run(1, 8'b1001_0010, 9);
    scan_run(0, 8'b0011_1000, 1);
    scan_run(0, 8'b0011_1000, 0);
    for (int it = 0; it < 4; it++) begin
      lat = 1 + int'($urandom % 30);
      scan_run(1'($urandom), 8'($urandom), 8);
    end
    lat = 6;

    // R11: commands while scanning do nothing
    wr(3'd2, 8'h01);
    b0 = logn;
    wr(3'd0, 8'h01);
    wr(3'd1, 8'd2);
    wr(3'd1, 8'd7);
    wr(3'd0, 8'h00);
    repeat (50) @(negedge clk);
    tagc = 0;
    for (int k = b0; k < logn && k < LOGMAX; k++) if (logt[k] != 0) tagc++;
    chk(logn > b0, "R11 scan ran", logn - b0, 1);
    chk(tagc == 0, "R11 cmd during scan", tagc, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule